// File: doc/BRIEF.md
# PLL Reconfiguration Sequencer

This block is a memory-mapped bus master that reloads the reconfiguration register bank of a fractional PLL in a fixed order. After a one-cycle `start` pulse it writes the polling-mode selection, the feedback multiplier, the fractional multiplier, the pre-divider, one word per output counter, the loop bandwidth code and the charge-pump code. It then writes the launch register and keeps reading the status register until bit 0 comes back set.

The target settings are parameters, so a fixed set of clock plans can be built into the chip without software. Each bus transaction waits for the slave's `waitrequest` to fall. The number of status reads is bounded. If the PLL never reports completion, a timeout flag is raised and the block returns to idle. The flag stays set until the next accepted start.

Top module: `pll_reconf_seq`

## Requirements
- R1: After a synchronous reset, `avm_write`, `avm_read`, `busy`, `done` and `timeout` are all low.
- R2: A start pulse accepted in idle produces writes to addresses 0x00, 0x04, 0x07, 0x03, then 0x05 once per output counter (counter 0 first), then 0x08, 0x09 and finally 0x02, in exactly this order, with no other transaction between them.
- R3: The write data are: mode 1 (polling), feedback multiplier 36, fractional word round(0.2666667 × 2^32), pre-divider 4, bandwidth code 6, charge-pump code 2 and launch word 1 (default parameters).
- R4: Each output-counter word carries the counter index in bits [22:18], an odd-division flag in bit 17, the high count in bits [15:8] and the low count in bits [7:0], with all other bits zero. With the defaults, counter 0 gives 0x00000303 and counter 1 gives 0x00040404.
- R5: While `waitrequest` is high, the pending `avm_write` or `avm_read`, `avm_address` and `avm_writedata` hold their values. A transaction completes on the first cycle with `waitrequest` low.
- R6: After the launch write, the block reads address 0x01 back to back. The first accepted read with bit 0 set ends the run: `done` is high for exactly one cycle, and `busy` and `avm_read` drop on the same edge.
- R7: If `POLL_LIMIT` accepted reads all return bit 0 clear, the block stops reading, sets `timeout`, leaves `done` low and returns to idle.
- R8: If the read that exhausts the poll limit returns bit 0 set, the run counts as a success: `done` pulses and `timeout` stays low.
- R9: `timeout` remains set in idle until the next accepted start, which clears it on the same edge that raises `busy`.
- R10: A start pulse that arrives while `busy` is high is ignored, and the running sequence continues unchanged.
- R11: `busy` is high from the edge that accepts start until the run ends. `avm_read` and `avm_write` are never high together, and neither is high while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to run the sequence |
| avm_address | output | ADDR_W | Register address of the current transaction |
| avm_write | output | 1 | Write request |
| avm_writedata | output | 32 | Write data |
| avm_read | output | 1 | Read request |
| avm_readdata | input | 32 | Read data, valid when a read is accepted |
| avm_waitrequest | input | 1 | Slave stall; the transaction is held while high |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse on successful completion |
| timeout | output | 1 | Sticky flag: status never reported completion |

## Verification
The two functions that can fall in the same cycle are poll-limit exhaustion and detection of the completion status. They coincide when the last allowed read is also the first that returns bit 0 set. The bench provokes this with a behavioural slave whose status turns set exactly on read number `POLL_LIMIT`, and judges the run by `done` pulsing once with `timeout` low. The neighbouring case, where the status turns set one read later, must instead yield a timeout with no `done`. A second overlap, a new start arriving mid-sequence, is provoked under random wait states; a scoreboard of the expected transaction stream shows whether it was ignored.

// File: rtl/pllseq_pkg.sv
package pllseq_pkg;

  localparam int WORD_W = 32;

  // Register map of the reconfiguration bank
  localparam int RA_MODE   = 'h00;
  localparam int RA_STATUS = 'h01;
  localparam int RA_LAUNCH = 'h02;
  localparam int RA_PREDIV = 'h03;
  localparam int RA_FBMUL  = 'h04;
  localparam int RA_OUTCNT = 'h05;
  localparam int RA_FRAC   = 'h07;
  localparam int RA_LOOPBW = 'h08;
  localparam int RA_PUMP   = 'h09;

  localparam int FIXED_STEPS = 7;  // steps other than output counters

  typedef enum logic [1:0] {
    S_IDLE,
    S_WRITE,
    S_POLL
  } seq_state_t;

  // Output counter word: index[22:18], odd[17], high[15:8], low[7:0]
  function automatic logic [WORD_W-1:0] pack_outcnt(
    input logic [4:0] idx,
    input logic       odd,
    input logic [7:0] hi,
    input logic [7:0] lo
  );
    return {9'd0, idx, odd, 1'b0, hi, lo};
  endfunction

endpackage

// File: rtl/pllseq_step_table.sv
module pllseq_step_table
  import pllseq_pkg::*;
#(
  parameter int          ADDR_W   = 6,
  parameter int          NUM_C    = 2,
  parameter int          MODE_VAL = 1,
  parameter int          FB_MUL   = 36,
  parameter logic [31:0] FRAC_K   = 32'd1145324755,
  parameter int          PRE_DIV  = 4,
  parameter logic [8*NUM_C-1:0] C_HIGH = {8'd4, 8'd3},
  parameter logic [8*NUM_C-1:0] C_LOW  = {8'd4, 8'd3},
  parameter logic [NUM_C-1:0]   C_ODD  = '0,
  parameter int          BW_CODE  = 6,
  parameter int          CP_CODE  = 2,
  localparam int         N_STEPS  = FIXED_STEPS + NUM_C,
  localparam int         STEP_W   = $clog2(N_STEPS)
) (
  input  logic [STEP_W-1:0] idx,
  output logic [ADDR_W-1:0] addr,
  output logic [WORD_W-1:0] data
);

  logic [ADDR_W-1:0] t_addr [N_STEPS];
  logic [WORD_W-1:0] t_data [N_STEPS];

  assign t_addr[0] = ADDR_W'(RA_MODE);
  assign t_data[0] = WORD_W'(MODE_VAL);
  assign t_addr[1] = ADDR_W'(RA_FBMUL);
  assign t_data[1] = WORD_W'(FB_MUL);
  assign t_addr[2] = ADDR_W'(RA_FRAC);
  assign t_data[2] = FRAC_K;
  assign t_addr[3] = ADDR_W'(RA_PREDIV);
  assign t_data[3] = WORD_W'(PRE_DIV);

  for (genvar g = 0; g < NUM_C; g++) begin : g_outcnt
    assign t_addr[4+g] = ADDR_W'(RA_OUTCNT);
    assign t_data[4+g] = pack_outcnt(5'(g), C_ODD[g], C_HIGH[8*g +: 8], C_LOW[8*g +: 8]);
  end

  assign t_addr[4+NUM_C] = ADDR_W'(RA_LOOPBW);
  assign t_data[4+NUM_C] = WORD_W'(BW_CODE);
  assign t_addr[5+NUM_C] = ADDR_W'(RA_PUMP);
  assign t_data[5+NUM_C] = WORD_W'(CP_CODE);
  assign t_addr[6+NUM_C] = ADDR_W'(RA_LAUNCH);
  assign t_data[6+NUM_C] = WORD_W'(1);

  assign addr = t_addr[idx];
  assign data = t_data[idx];

endmodule

// File: rtl/pllseq_poll_ctr.sv
module pllseq_poll_ctr #(
  parameter int  LIMIT = 1024,
  localparam int CNT_W = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic inc,
  output logic at_last
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt <= '0;
    end else if (inc && !at_last) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign at_last = (cnt == CNT_W'(LIMIT - 1));

  // The count of failed reads never passes the last permitted one
  p_cnt_range_r7: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(LIMIT - 1));

endmodule

// File: rtl/pll_reconf_seq.sv
module pll_reconf_seq
  import pllseq_pkg::*;
#(
  parameter int          ADDR_W     = 6,
  parameter int          NUM_C      = 2,
  parameter int          POLL_LIMIT = 1024,
  parameter int          MODE_VAL   = 1,
  parameter int          FB_MUL     = 36,
  parameter logic [31:0] FRAC_K     = 32'd1145324755,
  parameter int          PRE_DIV    = 4,
  parameter logic [8*NUM_C-1:0] C_HIGH = {8'd4, 8'd3},
  parameter logic [8*NUM_C-1:0] C_LOW  = {8'd4, 8'd3},
  parameter logic [NUM_C-1:0]   C_ODD  = '0,
  parameter int          BW_CODE    = 6,
  parameter int          CP_CODE    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic [ADDR_W-1:0] avm_address,
  output logic              avm_write,
  output logic [31:0]       avm_writedata,
  output logic              avm_read,
  input  logic [31:0]       avm_readdata,
  input  logic              avm_waitrequest,
  output logic              busy,
  output logic              done,
  output logic              timeout
);

  localparam int N_STEPS = FIXED_STEPS + NUM_C;
  localparam int STEP_W  = $clog2(N_STEPS);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(N_STEPS - 1);

  seq_state_t        state;
  logic [STEP_W-1:0] step;
  logic [STEP_W-1:0] tbl_idx;
  logic [ADDR_W-1:0] tbl_addr;
  logic [WORD_W-1:0] tbl_data;
  logic              poll_last;
  logic              accepted;
  logic              status_set;

  assign accepted   = !avm_waitrequest;
  assign status_set = avm_readdata[0];
  assign tbl_idx    = (state == S_IDLE) ? '0 : step + 1'b1;

  pllseq_step_table #(
    .ADDR_W(ADDR_W), .NUM_C(NUM_C), .MODE_VAL(MODE_VAL), .FB_MUL(FB_MUL),
    .FRAC_K(FRAC_K), .PRE_DIV(PRE_DIV), .C_HIGH(C_HIGH), .C_LOW(C_LOW),
    .C_ODD(C_ODD), .BW_CODE(BW_CODE), .CP_CODE(CP_CODE)
  ) u_table (
    .idx (tbl_idx),
    .addr(tbl_addr),
    .data(tbl_data)
  );

  pllseq_poll_ctr #(.LIMIT(POLL_LIMIT)) u_poll (
    .clk    (clk),
    .rst    (rst),
    .clear  (state != S_POLL),
    .inc    (state == S_POLL && accepted && !status_set),
    .at_last(poll_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= S_IDLE;
      step          <= '0;
      avm_address   <= '0;
      avm_write     <= 1'b0;
      avm_writedata <= '0;
      avm_read      <= 1'b0;
      busy          <= 1'b0;
      done          <= 1'b0;
      timeout       <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start) begin
            state         <= S_WRITE;
            step          <= '0;
            avm_address   <= tbl_addr;
            avm_writedata <= tbl_data;
            avm_write     <= 1'b1;
            busy          <= 1'b1;
            timeout       <= 1'b0;
          end
        end
        S_WRITE: begin
          if (accepted) begin
            if (step == LAST_STEP) begin
              state         <= S_POLL;
              avm_write     <= 1'b0;
              avm_read      <= 1'b1;
              avm_address   <= ADDR_W'(RA_STATUS);
              avm_writedata <= '0;
            end else begin
              step          <= step + 1'b1;
              avm_address   <= tbl_addr;
              avm_writedata <= tbl_data;
            end
          end
        end
        S_POLL: begin
          if (accepted && (status_set || poll_last)) begin
            state    <= S_IDLE;
            avm_read <= 1'b0;
            busy     <= 1'b0;
            done     <= status_set;
            timeout  <= !status_set;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R11: one request kind at a time, and only inside a run
  p_rw_excl_r11: assert property (@(posedge clk) disable iff (rst)
    !(avm_write && avm_read));
  p_req_in_run_r11: assert property (@(posedge clk) disable iff (rst)
    (avm_write || avm_read) |-> busy);

  // R5: stalled requests keep their address and data
  p_hold_wr_r5: assert property (@(posedge clk) disable iff (rst)
    (avm_write && avm_waitrequest) |=>
      (avm_write && $stable(avm_address) && $stable(avm_writedata)));
  p_hold_rd_r5: assert property (@(posedge clk) disable iff (rst)
    (avm_read && avm_waitrequest) |=> (avm_read && $stable(avm_address)));

  // R6: completion is a single-cycle pulse that ends the run
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_done_idle_r6: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && !avm_read));

  // R8: success and timeout never report together
  p_no_both_r8: assert property (@(posedge clk) disable iff (rst)
    !(done && timeout));

  // R10: a second start during a run does not restart the write stream
  p_no_restart_r10: assert property (@(posedge clk) disable iff (rst)
    (busy && start && avm_write && avm_waitrequest) |=> $stable(avm_address));

endmodule

// File: tb/pll_reconf_seq_tb.sv
module pll_reconf_seq_tb;

  localparam int LIMIT  = 8;
  localparam int ADDR_W = 6;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic [ADDR_W-1:0] avm_address;
  logic              avm_write;
  logic [31:0]       avm_writedata;
  logic              avm_read;
  logic [31:0]       avm_readdata = '0;
  logic              avm_waitrequest = 1'b0;
  logic              busy, done, timeout;

  always #2 clk = ~clk;  // 250 MHz

  pll_reconf_seq #(.ADDR_W(ADDR_W), .POLL_LIMIT(LIMIT)) u_dut (
    .clk(clk), .rst(rst), .start(start),
    .avm_address(avm_address), .avm_write(avm_write),
    .avm_writedata(avm_writedata), .avm_read(avm_read),
    .avm_readdata(avm_readdata), .avm_waitrequest(avm_waitrequest),
    .busy(busy), .done(done), .timeout(timeout)
  );

  typedef struct {
    bit          wr;
    logic [5:0]  a;
    logic [31:0] d;
    string       req;
  } txn_t;

  txn_t exp_q[$];
  int   checks = 0;
  int   errors = 0;
  int   cfg_ready = 0;
  bit   cfg_stall = 1'b0;
  int   reads_done = 0;
  int   done_cnt = 0;
  logic [7:0] lfsr = 8'hA5;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=0x%08h expected=0x%08h", req, what, act, exp);
    end
  endtask

  task automatic push_w(input int a, input logic [31:0] d, input string req);
    txn_t t;
    t.wr = 1'b1; t.a = 6'(a); t.d = d; t.req = req;
    exp_q.push_back(t);
  endtask

  // Behavioural slave and scoreboard monitor
  initial begin
    bit          prev_hold = 1'b0;
    bit          prev_wr = 1'b0;
    logic [5:0]  prev_a = '0;
    logic [31:0] prev_d = '0;
    forever begin
      @(negedge clk);
      if (cfg_stall) begin
        avm_waitrequest = lfsr[0];
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      end else begin
        avm_waitrequest = 1'b0;
      end
      avm_readdata = (reads_done >= cfg_ready) ? 32'd1 : 32'd0;
      #1;
      if (prev_hold) begin
        chk((prev_wr ? avm_write : avm_read) && avm_address == prev_a &&
            avm_writedata == prev_d, "R5", "stalled request changed",
            {26'd0, avm_address}, {26'd0, prev_a});
      end
      prev_hold = (avm_write || avm_read) && avm_waitrequest;
      prev_wr = avm_write;
      prev_a = avm_address;
      prev_d = avm_writedata;
      if ((avm_write || avm_read) && !avm_waitrequest) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2", "unexpected transaction at address",
              {26'd0, avm_address}, 32'hFFFF_FFFF);
        end else begin
          txn_t t;
          t = exp_q.pop_front();
          chk(avm_write == t.wr, t.req, "transaction kind", {31'd0, avm_write}, {31'd0, t.wr});
          chk(avm_address == t.a, t.req, "address", {26'd0, avm_address}, {26'd0, t.a});
          if (t.wr)
            chk(avm_writedata == t.d, t.req, "write data", avm_writedata, t.d);
        end
        if (avm_read) reads_done++;
      end
      if (done) done_cnt++;
    end
  end

  task automatic run_case(input int ready_after, input bit stall, input bit restart_try);
    int  nreads;
    bit  ok_run;
    logic [31:0] frac;
    frac = 32'(longint'(0.2666667 * 4294967296.0));
    ok_run = (ready_after < LIMIT);
    nreads = ok_run ? ready_after + 1 : LIMIT;
    cfg_ready = ready_after;
    cfg_stall = stall;
    reads_done = 0;
    done_cnt = 0;
    push_w('h00, 32'd1, "R3 mode");
    push_w('h04, 32'd36, "R3 feedback");
    push_w('h07, frac, "R3 fraction");
    push_w('h03, 32'd4, "R3 prediv");
    push_w('h05, 32'h0000_0303, "R4 counter0");
    push_w('h05, 32'h0004_0404, "R4 counter1");
    push_w('h08, 32'd6, "R3 bandwidth");
    push_w('h09, 32'd2, "R3 pump");
    push_w('h02, 32'd1, "R2 launch");
    for (int i = 0; i < nreads; i++) begin
      txn_t t;
      t.wr = 1'b0; t.a = 6'h01; t.d = '0; t.req = "R6 status poll";
      exp_q.push_back(t);
    end
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    #2;
    chk(busy == 1'b1, "R11", "busy after start", {31'd0, busy}, 32'd1);
    chk(timeout == 1'b0, "R9", "timeout cleared by start", {31'd0, timeout}, 32'd0);
    if (restart_try) begin
      repeat (3) @(negedge clk);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    while (busy) begin
      @(negedge clk);
      #2;
    end
    repeat (3) @(negedge clk);
    #2;
    chk(exp_q.size() == 0, "R2", "transactions left over", 32'(exp_q.size()), 32'd0);
    exp_q.delete();
    chk(done_cnt == (ok_run ? 1 : 0), ok_run ? "R6" : "R7", "done pulses",
        32'(done_cnt), ok_run ? 32'd1 : 32'd0);
    chk(timeout == !ok_run, ok_run ? "R8" : "R7", "timeout flag",
        {31'd0, timeout}, {31'd0, !ok_run});
    chk(!avm_read && !avm_write, "R11", "bus idle after run",
        {30'd0, avm_read, avm_write}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #2;
    chk(!avm_write && !avm_read && !busy && !done && !timeout, "R1",
        "outputs after reset", {27'd0, avm_write, avm_read, busy, done, timeout}, 32'd0);
    run_case(0, 1'b0, 1'b0);          // R6 immediate completion
    run_case(3, 1'b1, 1'b1);          // R5 stalls, R10 ignored restart
    run_case(LIMIT - 1, 1'b1, 1'b0);  // R8 success on the last allowed read
    run_case(LIMIT, 1'b0, 1'b0);      // R7 timeout
    repeat (6) @(negedge clk);
    #2;
    chk(timeout == 1'b1, "R9", "timeout sticky in idle", {31'd0, timeout}, 32'd1);
    run_case(2, 1'b1, 1'b0);          // R9 cleared by the next run
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog run did not finish actual=0x%08h expected=0x%08h", 32'd1, 32'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule